// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a parallel-in, serial-out shift register with a parameterised number of stages (eight by default). Stage 0 is the first stage and the highest-numbered stage is the last. A shift moves every stage one position toward the last stage and brings the serial input into stage 0. The last stage drives a true serial output and its complement. An active-low shift/load control loads all stages from the parallel inputs while it is low, and this load takes priority over every other input.

The shift clock comes from two external pins, a clock pin and an inhibit pin, which play the same role. The block samples both pins as synchronous signals in its system-clock domain and combines them by OR. Each 0-to-1 transition of that OR gives exactly one shift. So a rising edge on either pin while the other pin is low shifts the register, and holding either pin high stops all shifting. A parallel view of all stages is brought out for observation.

Top module: `gated_piso_shifter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every stage clears to 0. After reset, `serialOut` is 0 and `serialOutN` is 1.
- R2: While `shiftLoadN` is low, each rising edge of `clk` copies `parallelIn[i]` into stage i. The values of `gateClk`, `gateInh` and `serialIn` do not matter.
- R3: With `shiftLoadN` high and `gateInh` low, a 0-to-1 change of `gateClk` causes one shift. Stage 0 takes `serialIn` and stage i takes the old stage i-1. The result appears on the outputs after the second rising edge of `clk` that follows the pin change.
- R4: With `shiftLoadN` high and `gateClk` low, a 0-to-1 change of `gateInh` causes one shift, the same as in R3.
- R5: With `shiftLoadN` high, the stages keep their values unless the OR of the two pins rises. While either pin is held high, toggling the other pin causes no shift.
- R6: Each rising edge of the OR causes exactly one shift, however long the pins then stay high.
- R7: `serialOut` always equals the last stage, and `serialOutN` is always its complement.
- R8: With `shiftLoadN` high, changes on `parallelIn` have no effect on any stage.
- R9: If the OR of the pins is already high while `shiftLoadN` is low, releasing `shiftLoadN` causes no shift. The next shift needs a fresh rising edge of the OR.
- R10: After a load, STAGES successive shifts put the loaded word on `serialOut` starting with `parallelIn[STAGES-1]` and ending with `parallelIn[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shiftLoadN | input | 1 | Low: parallel load; high: shift/hold |
| gateClk | input | 1 | External shift clock pin, sampled synchronously |
| gateInh | input | 1 | Inhibit pin, interchangeable with `gateClk` |
| serialIn | input | 1 | Data entering stage 0 on a shift |
| parallelIn | input | STAGES | Load data; bit i feeds stage i |
| serialOut | output | 1 | Last stage |
| serialOutN | output | 1 | Complement of the last stage |
| stageView | output | STAGES | All stage values; bit i is stage i |

## Verification
The bench builds the block with its default of STAGES = 8. At that size the stage view can be compared against a byte-wide reference after every step. A full serialisation of a loaded byte takes only eight clock pulses, so the ordering from the last stage down to the first can be traced one bit at a time. The width is small enough to try a load that ignores a moving clock, inhibit-driven shifts, and a hold with the inhibit pin set, all against the same reference word.

// File: rtl/piso_pkg.sv
package piso_pkg;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic loadNow;   // copy the parallel inputs this cycle
    logic shiftNow;  // advance one position this cycle
  } strobe_t;

endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl (
  input  logic              clk,
  input  logic              rst,
  input  logic              shiftLoadN,
  input  logic              gateClk,
  input  logic              gateInh,
  output piso_pkg::strobe_t strobes
);

  // Pin samples in the system-clock domain.
  logic clkQ;
  logic inhQ;
  logic orPrev;
  logic orNow;
  logic orRise;

  assign orNow  = clkQ | inhQ;
  assign orRise = orNow & ~orPrev;

  // The history follows the OR on every cycle. During reset and load it
  // therefore holds the current level, so leaving either state with a pin
  // already high cannot look like a rising edge.
  always_ff @(posedge clk) begin
    clkQ   <= gateClk;
    inhQ   <= gateInh;
    orPrev <= orNow;
  end

  always_comb begin
    strobes.loadNow  = ~shiftLoadN & ~rst;
    strobes.shiftNow = shiftLoadN & ~rst & orRise;
  end

  // One rising edge of the OR gives a single-cycle strobe.
  AST_SHIFT_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftNow |=> !strobes.shiftNow);  // R6

  // Load and shift never ask for the register at the same time.
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(strobes.loadNow && strobes.shiftNow));  // R2

endmodule

// File: rtl/piso_datapath.sv
module piso_datapath #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  piso_pkg::strobe_t strobes,
  input  logic              serialIn,
  input  logic [STAGES-1:0] parallelIn,
  output logic [STAGES-1:0] stages
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] nextStages;

  // One selector per stage: load, then shift, otherwise keep.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic shiftSrc;
    if (i == 0) begin : g_head
      assign shiftSrc = serialIn;
    end else begin : g_body
      assign shiftSrc = stages[i-1];
    end

    always_comb begin
      if (strobes.loadNow)       nextStages[i] = parallelIn[i];
      else if (strobes.shiftNow) nextStages[i] = shiftSrc;
      else                       nextStages[i] = stages[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= nextStages;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> stages == '0);  // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    strobes.loadNow |=> stages == $past(parallelIn));  // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftNow |=> stages == {$past(stages[LAST-1:0]), $past(serialIn)});  // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadNow && !strobes.shiftNow) |=> $stable(stages));  // R5

endmodule

// File: rtl/gated_piso_shifter.sv
module gated_piso_shifter #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shiftLoadN,
  input  logic              gateClk,
  input  logic              gateInh,
  input  logic              serialIn,
  input  logic [STAGES-1:0] parallelIn,
  output logic              serialOut,
  output logic              serialOutN,
  output logic [STAGES-1:0] stageView
);

  localparam int LAST = STAGES - 1;

  piso_pkg::strobe_t strobes;
  logic [STAGES-1:0] stages;

  piso_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .shiftLoadN (shiftLoadN),
    .gateClk    (gateClk),
    .gateInh    (gateInh),
    .strobes    (strobes)
  );

  piso_datapath #(.STAGES(STAGES)) u_data (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .serialIn   (serialIn),
    .parallelIn (parallelIn),
    .stages     (stages)
  );

  assign serialOut  = stages[LAST];
  assign serialOutN = ~stages[LAST];
  assign stageView  = stages;

endmodule

// File: tb/tb_gated_piso_shifter.sv
module tb_gated_piso_shifter;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shiftLoadN = 1'b1;
  logic         gateClk = 1'b0;
  logic         gateInh = 1'b0;
  logic         serialIn = 1'b0;
  logic [N-1:0] parallelIn = '0;
  logic         serialOut;
  logic         serialOutN;
  logic [N-1:0] stageView;

  logic [N-1:0] model;
  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gated_piso_shifter #(.STAGES(N)) dut (
    .clk        (clk),
    .rst        (rst),
    .shiftLoadN (shiftLoadN),
    .gateClk    (gateClk),
    .gateInh    (gateInh),
    .serialIn   (serialIn),
    .parallelIn (parallelIn),
    .serialOut  (serialOut),
    .serialOutN (serialOutN),
    .stageView  (stageView)
  );

  task automatic waitFalls(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Compare every output with the reference word.
  task automatic checkAll(input string tag);
    testCount++;
    if (stageView !== model || serialOut !== model[N-1] || serialOutN !== ~model[N-1]) begin
      failCount++;
      $display("FAIL %s: actual view=%h out=%b outN=%b expected view=%h out=%b outN=%b",
               tag, stageView, serialOut, serialOutN, model, model[N-1], ~model[N-1]);
    end
  endtask

  task automatic doLoad(input logic [N-1:0] word);
    shiftLoadN = 1'b0;
    parallelIn = word;
    waitFalls(1);
    shiftLoadN = 1'b1;
    model = word;
  endtask

  task automatic testReset();
    waitFalls(3);
    model = '0;
    checkAll("R1 reset clears stages");
    rst = 1'b0;
    waitFalls(2);
    checkAll("R1 idle after reset");
  endtask

  task automatic testLoadIgnoresOthers();
    shiftLoadN = 1'b0;
    parallelIn = 8'h5A;
    for (int k = 0; k < 4; k++) begin
      gateClk  = k[0];
      gateInh  = k[1];
      serialIn = ~k[0];
      waitFalls(1);
    end
    model = 8'h5A;
    checkAll("R2 load overrides clock and serial");
    parallelIn = 8'hC3;
    waitFalls(1);
    model = 8'hC3;
    checkAll("R2 load follows new inputs");
    gateClk = 1'b0;
    gateInh = 1'b0;
    waitFalls(1);
    shiftLoadN = 1'b1;
    waitFalls(2);
    checkAll("R2 release with pins low holds");
  endtask

  task automatic testClockShift();
    doLoad(8'h81);
    serialIn = 1'b1;
    gateClk = 1'b1;
    waitFalls(1);
    checkAll("R3 not yet shifted after one edge");
    waitFalls(1);
    model = {model[N-2:0], 1'b1};
    checkAll("R3 shift from clock pin");
    waitFalls(4);
    checkAll("R6 clock held high gives one shift");
    gateClk = 1'b0;
    waitFalls(2);
    checkAll("R5 falling clock holds");
  endtask

  task automatic testInhibitShift();
    serialIn = 1'b0;
    gateInh = 1'b1;
    waitFalls(2);
    model = {model[N-2:0], 1'b0};
    checkAll("R4 shift from inhibit pin");
    waitFalls(3);
    checkAll("R6 inhibit held high gives one shift");
    gateInh = 1'b0;
    waitFalls(2);
  endtask

  task automatic testInhibitHold();
    serialIn = 1'b1;
    gateClk = 1'b1;
    waitFalls(2);
    model = {model[N-2:0], 1'b1};
    checkAll("R3 shift before inhibit");
    gateInh = 1'b1;
    waitFalls(2);
    for (int k = 0; k < 4; k++) begin
      gateClk = ~gateClk;
      waitFalls(2);
    end
    checkAll("R5 inhibit high blocks clock toggles");
    gateClk = 1'b1;
    waitFalls(2);
    gateInh = 1'b0;
    waitFalls(2);
    gateClk = 1'b0;
    waitFalls(2);
    checkAll("R5 inhibit released under high clock");
  endtask

  task automatic testParallelIgnored();
    for (int k = 0; k < 5; k++) begin
      parallelIn = 8'h11 * k[7:0] + 8'h07;
      waitFalls(1);
    end
    checkAll("R8 parallel inputs ignored in shift mode");
  endtask

  task automatic testLoadWithClockHigh();
    shiftLoadN = 1'b0;
    parallelIn = 8'h3C;
    gateClk = 1'b1;
    waitFalls(2);
    shiftLoadN = 1'b1;
    model = 8'h3C;
    waitFalls(3);
    checkAll("R9 no shift on release with clock high");
    gateClk = 1'b0;
    serialIn = 1'b0;
    waitFalls(2);
    gateClk = 1'b1;
    waitFalls(2);
    model = {model[N-2:0], 1'b0};
    checkAll("R9 fresh edge shifts");
    gateClk = 1'b0;
    waitFalls(2);
  endtask

  task automatic testSerialize();
    logic [N-1:0] word = 8'hB4;
    logic [N-1:0] seen = '0;
    doLoad(word);
    serialIn = 1'b0;
    waitFalls(1);
    for (int k = 0; k < N; k++) begin
      seen[N-1-k] = serialOut;
      gateClk = 1'b1;
      waitFalls(2);
      model = {model[N-2:0], 1'b0};
      gateClk = 1'b0;
      waitFalls(2);
    end
    testCount++;
    if (seen !== word) begin
      failCount++;
      $display("FAIL R10 serial order: actual=%h expected=%h", seen, word);
    end
    checkAll("R10 register empty after serialize");
    checkAll("R7 complement after serialize");
  endtask

  initial begin
    testReset();
    testLoadIgnoresOthers();
    testClockShift();
    testInhibitShift();
    testInhibitHold();
    testParallelIgnored();
    testLoadWithClockHigh();
    testSerialize();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      failCount++;
      $display("FAIL WDG: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule